// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Transfer Controller

This block turns one multi-byte read or write request into the sequence of byte-level commands needed on a two-wire serial bus. It does not drive the bus lines itself. It hands each byte operation to a separate byte engine over a command/status handshake. The engine reports, for each command, whether the device acknowledged it and, for reads, the byte it received. Transfer data lives in a small internal buffer. The host fills this buffer before a write and reads it back after a read, while the controller is idle.

Two addressing styles are supported. In register-addressed mode, the controller sends a device-address byte and then a one-byte offset. A read then waits out a bus-free gap, issues a repeated START with the read bit, and collects the data. In legacy mode, the offset is shifted left by one and carries the read/write bit in bit 0. That single byte replaces both the device byte and the offset byte.

Writes are cut into chunks of at most `CHUNK` bytes, and each chunk is its own addressed transaction ending in STOP. After each chunk the controller polls the device with read-address STARTs until the device acknowledges. It then reads and discards one byte, advances the offset by `CHUNK`, and starts the next chunk.

Top module: `tws_xfer_ctrl`

## Requirements
- R1: In register-addressed mode, a transfer opens with a write command carrying START and the byte {req_dev[6:0], 1'b0}. The offset byte follows as a write command with neither START nor STOP. A read then continues with a write command carrying START and the byte {req_dev[6:0], 1'b1}, with no STOP in between.
- R2: In a register-addressed read, the read-address command is offered no earlier than `GAP_CYCLES` cycles after the response to the offset byte.
- R3: In legacy mode, the first command carries START and the byte {offset[6:0], rw}, where rw is 1 for a read and 0 for a write. No device byte and no offset byte are sent.
- R4: Read bytes are fetched one per command. Every byte except the last uses cmd_op 1 (read and ACK). The last byte uses cmd_op 2 (read and NACK) with cmd_stop set. Byte i of the transfer is stored in buffer entry i.
- R5: Writes go out in chunks of at most `CHUNK` data bytes, where data byte i comes from buffer entry i. Each chunk is re-addressed with START, and its last data byte carries cmd_stop. The offset of each chunk is `CHUNK` greater than the offset of the previous chunk.
- R6: After each write chunk, the controller repeats a START with the byte {req_dev[6:0], 1'b1} until the device acknowledges. It then issues one read-and-NACK command with STOP and discards the byte.
- R7: A missing acknowledge on the device/legacy byte or on the offset byte ends the transfer. The controller issues a STOP-only command (cmd_op 3, cmd_stop set), and done comes with err_code 1.
- R8: If `poll_limit` poll attempts in a row are not acknowledged, the controller issues a STOP-only command and finishes with err_code 3.
- R9: A missing acknowledge on a write data byte ends the transfer with a STOP-only command and err_code 2. A transfer that completes normally reports err_code 0.
- R10: A request with zero length raises done with err_code 0 and issues no command.
- R11: While cmd_valid is high and cmd_ready is low, cmd_op, cmd_start, cmd_stop and cmd_data stay unchanged. The cmd_op codes are 0 (write byte), 1 (read with ACK), 2 (read with NACK) and 3 (STOP only).
- R12: After reset, busy, done and cmd_valid are low.
- R13: A request raised while busy is high is ignored, and the running command sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transfer (taken only while idle) |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_legacy | input | 1 | Selects legacy addressing (offset folded into first byte) |
| req_dev | input | 7 | Seven-bit device address |
| req_offset | input | 8 | Starting offset inside the device |
| req_len | input | LEN_W | Byte count, 0 to BUF_DEPTH |
| poll_limit | input | POLL_W | Maximum acknowledge-poll attempts per chunk |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err_code | output | 2 | 0 ok, 1 address/offset NACK, 2 data NACK, 3 poll timeout |
| hb_we | input | 1 | Host buffer write enable (acted on while idle) |
| hb_addr | input | AW | Host buffer write index |
| hb_wdata | input | 8 | Host buffer write data |
| hb_raddr | input | AW | Host buffer read index |
| hb_rdata | output | 8 | Host buffer read data, one cycle after hb_raddr |
| cmd_valid | output | 1 | Byte command offered to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 2 | Command code (see R11) |
| cmd_start | output | 1 | Engine sends START before the byte |
| cmd_stop | output | 1 | Engine sends STOP after the operation |
| cmd_data | output | 8 | Byte to transmit |
| rsp_valid | input | 1 | Engine finished the accepted command |
| rsp_ack | input | 1 | Device acknowledged the byte |
| rsp_data | input | 8 | Byte received on a read |

## Verification
The bench builds the controller with `BUF_DEPTH`=16, `CHUNK`=4, `GAP_CYCLES`=8 and `POLL_W`=4. The short gap keeps read transfers quick while still letting the bench measure the gap in cycles. The 4-byte chunk with lengths of 5 and 6 forces a second chunk, so the offset advance and the re-addressing of a chunk are exercised in both addressing modes. The 4-bit poll limit makes a poll timeout reachable after three refused attempts, and a one-in-three stalled cmd_ready exercises command holding on every transfer.

// File: rtl/tws_xfer_pkg.sv
package tws_xfer_pkg;

  typedef enum logic [1:0] {
    OP_WRITE     = 2'd0,
    OP_READ_ACK  = 2'd1,
    OP_READ_NACK = 2'd2,
    OP_STOP      = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_ADDR_NACK = 2'd1,
    ERR_DATA_NACK = 2'd2,
    ERR_POLL_TMO  = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_OFFS, S_GAP, S_RADDR, S_RDATA,
    S_WLOAD, S_WFETCH, S_WDATA, S_POLL, S_PDRAIN, S_ABORT
  } st_e;

  typedef struct packed {
    op_e        op;
    logic       start;
    logic       stop;
    logic [7:0] data;
  } cmd_t;

  function automatic cmd_t mk_cmd(op_e op, logic start, logic stop, logic [7:0] data);
    cmd_t c;
    c.op    = op;
    c.start = start;
    c.stop  = stop;
    c.data  = data;
    return c;
  endfunction

endpackage

// File: rtl/tws_xfer_buf.sv
module tws_xfer_buf #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end

endmodule

// File: rtl/tws_gap_timer.sv
module tws_gap_timer #(
  parameter  int CYCLES = 60,
  localparam int CW     = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic running
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= CW'(CYCLES);
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign running = (cnt != '0);

  // R2: the gap is only armed from rest
  p_load_rest_r2: assert property (@(posedge clk) disable iff (rst)
    load |-> cnt == '0);

  // R2: the gap counts down one step per cycle, never skipping
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !load) |=> cnt == $past(cnt) - CW'(1));

endmodule

// File: rtl/tws_xfer_seq.sv
module tws_xfer_seq
  import tws_xfer_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int CHUNK  = 4,
  parameter  int POLL_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1),
  localparam int CW     = $clog2(CHUNK + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_legacy,
  input  logic [6:0]        req_dev,
  input  logic [7:0]        req_offset,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output err_e              err_code,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output cmd_t              cmd_q,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic [7:0]        rsp_data,
  output logic              buf_we,
  output logic [AW-1:0]     buf_waddr,
  output logic [7:0]        buf_wdata,
  output logic [AW-1:0]     buf_raddr,
  input  logic [7:0]        buf_rdata,
  output logic              gap_load,
  input  logic              gap_running
);

  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK);

  st_e               state;
  logic              wr_q, leg_q;
  logic [6:0]        dev_q;
  logic [7:0]        off_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CW-1:0]     chunk_q;
  logic [AW-1:0]     idx_q;
  logic [POLL_W-1:0] poll_q, plim_q;
  logic              got;
  logic [7:0]        off_next;

  function automatic logic [CW-1:0] first_chunk(logic [LEN_W-1:0] rem);
    return (rem > CHUNK_L) ? CW'(CHUNK_L) : CW'(rem);
  endfunction

  function automatic cmd_t rd_cmd(logic [LEN_W-1:0] rem);
    return (rem == LEN_W'(1)) ? mk_cmd(OP_READ_NACK, 1'b0, 1'b1, 8'h00)
                              : mk_cmd(OP_READ_ACK,  1'b0, 1'b0, 8'h00);
  endfunction

  assign got       = rsp_valid && !cmd_valid;
  assign buf_raddr = idx_q;
  assign off_next  = off_q + 8'(CHUNK);
  assign gap_load  = (state == S_OFFS) && got && rsp_ack && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cmd_valid <= 1'b0;
      cmd_q     <= mk_cmd(OP_WRITE, 1'b0, 1'b0, 8'h00);
      busy      <= 1'b0;
      done      <= 1'b0;
      err_code  <= ERR_NONE;
      buf_we    <= 1'b0;
      buf_waddr <= '0;
      buf_wdata <= '0;
      wr_q      <= 1'b0;
      leg_q     <= 1'b0;
      dev_q     <= '0;
      off_q     <= '0;
      rem_q     <= '0;
      chunk_q   <= '0;
      idx_q     <= '0;
      poll_q    <= '0;
      plim_q    <= '0;
    end else begin
      done   <= 1'b0;
      buf_we <= 1'b0;
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;

      case (state)
        S_IDLE: begin
          if (req_valid) begin
            wr_q     <= req_write;
            leg_q    <= req_legacy;
            dev_q    <= req_dev;
            off_q    <= req_offset;
            rem_q    <= req_len;
            plim_q   <= poll_limit;
            chunk_q  <= first_chunk(req_len);
            idx_q    <= '0;
            poll_q   <= '0;
            err_code <= ERR_NONE;
            if (req_len == '0) begin
              done <= 1'b1;
            end else begin
              busy      <= 1'b1;
              state     <= S_ADDR;
              cmd_valid <= 1'b1;
              cmd_q     <= mk_cmd(OP_WRITE, 1'b1, 1'b0,
                                  req_legacy ? {req_offset[6:0], !req_write}
                                             : {req_dev, 1'b0});
            end
          end
        end

        S_ADDR: if (got) begin
          if (!rsp_ack) begin
            state     <= S_ABORT;
            err_code  <= ERR_ADDR_NACK;
            cmd_valid <= 1'b1;
            cmd_q     <= mk_cmd(OP_STOP, 1'b0, 1'b1, 8'h00);
          end else if (leg_q && wr_q) begin
            state <= S_WLOAD;
          end else if (leg_q) begin
            state     <= S_RDATA;
            cmd_valid <= 1'b1;
            cmd_q     <= rd_cmd(rem_q);
          end else begin
            state     <= S_OFFS;
            cmd_valid <= 1'b1;
            cmd_q     <= mk_cmd(OP_WRITE, 1'b0, 1'b0, off_q);
          end
        end

        S_OFFS: if (got) begin
          if (!rsp_ack) begin
            state     <= S_ABORT;
            err_code  <= ERR_ADDR_NACK;
            cmd_valid <= 1'b1;
            cmd_q     <= mk_cmd(OP_STOP, 1'b0, 1'b1, 8'h00);
          end else if (wr_q) begin
            state <= S_WLOAD;
          end else begin
            state <= S_GAP;
          end
        end

        S_GAP: if (!gap_running) begin
          state     <= S_RADDR;
          cmd_valid <= 1'b1;
          cmd_q     <= mk_cmd(OP_WRITE, 1'b1, 1'b0, {dev_q, 1'b1});
        end

        S_RADDR: if (got) begin
          if (!rsp_ack) begin
            state     <= S_ABORT;
            err_code  <= ERR_ADDR_NACK;
            cmd_valid <= 1'b1;
            cmd_q     <= mk_cmd(OP_STOP, 1'b0, 1'b1, 8'h00);
          end else begin
            state     <= S_RDATA;
            cmd_valid <= 1'b1;
            cmd_q     <= rd_cmd(rem_q);
          end
        end

        S_RDATA: if (got) begin
          buf_we    <= 1'b1;
          buf_waddr <= idx_q;
          buf_wdata <= rsp_data;
          idx_q     <= idx_q + AW'(1);
          rem_q     <= rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) begin
            state <= S_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            cmd_valid <= 1'b1;
            cmd_q     <= rd_cmd(rem_q - LEN_W'(1));
          end
        end

        S_WLOAD: state <= S_WFETCH;

        S_WFETCH: begin
          state     <= S_WDATA;
          cmd_valid <= 1'b1;
          cmd_q     <= mk_cmd(OP_WRITE, 1'b0, chunk_q == CW'(1), buf_rdata);
        end

        S_WDATA: if (got) begin
          if (!rsp_ack) begin
            state     <= S_ABORT;
            err_code  <= ERR_DATA_NACK;
            cmd_valid <= 1'b1;
            cmd_q     <= mk_cmd(OP_STOP, 1'b0, 1'b1, 8'h00);
          end else begin
            idx_q   <= idx_q + AW'(1);
            rem_q   <= rem_q - LEN_W'(1);
            chunk_q <= chunk_q - CW'(1);
            if (chunk_q == CW'(1)) begin
              state     <= S_POLL;
              poll_q    <= '0;
              cmd_valid <= 1'b1;
              cmd_q     <= mk_cmd(OP_WRITE, 1'b1, 1'b0, {dev_q, 1'b1});
            end else begin
              state <= S_WLOAD;
            end
          end
        end

        S_POLL: if (got) begin
          if (rsp_ack) begin
            state     <= S_PDRAIN;
            cmd_valid <= 1'b1;
            cmd_q     <= mk_cmd(OP_READ_NACK, 1'b0, 1'b1, 8'h00);
          end else if (poll_q + POLL_W'(1) >= plim_q) begin
            state     <= S_ABORT;
            err_code  <= ERR_POLL_TMO;
            cmd_valid <= 1'b1;
            cmd_q     <= mk_cmd(OP_STOP, 1'b0, 1'b1, 8'h00);
          end else begin
            poll_q    <= poll_q + POLL_W'(1);
            cmd_valid <= 1'b1;
            cmd_q     <= mk_cmd(OP_WRITE, 1'b1, 1'b0, {dev_q, 1'b1});
          end
        end

        S_PDRAIN: if (got) begin
          if (rem_q == '0) begin
            state <= S_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            off_q     <= off_next;
            chunk_q   <= first_chunk(rem_q);
            state     <= S_ADDR;
            cmd_valid <= 1'b1;
            cmd_q     <= mk_cmd(OP_WRITE, 1'b1, 1'b0,
                                leg_q ? {off_next[6:0], 1'b0} : {dev_q, 1'b0});
          end
        end

        S_ABORT: if (got) begin
          state <= S_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: an offered command holds still until the engine takes it
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_q)));

  // R4: the final read of a transfer or poll drain always closes the bus
  p_nack_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_q.op == OP_READ_NACK) |-> cmd_q.stop);

  // R1: START only ever precedes an address-type byte write
  p_start_write_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_q.start) |-> cmd_q.op == OP_WRITE);

  // R5: a chunk never exceeds the configured size
  p_chunk_bound_r5: assert property (@(posedge clk) disable iff (rst)
    chunk_q <= CW'(CHUNK));

  // R8: the poll attempt counter stays below the latched limit
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL && plim_q != '0) |-> poll_q < plim_q);

  // R10: completion is reported only once the sequencer is back at rest
  p_done_rest_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == S_IDLE && !busy && !cmd_valid));

endmodule

// File: rtl/tws_xfer_ctrl.sv
module tws_xfer_ctrl #(
  parameter  int BUF_DEPTH  = 16,
  parameter  int CHUNK      = 4,
  parameter  int GAP_CYCLES = 60,
  parameter  int POLL_W     = 8,
  localparam int AW         = $clog2(BUF_DEPTH),
  localparam int LEN_W      = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_legacy,
  input  logic [6:0]        req_dev,
  input  logic [7:0]        req_offset,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  input  logic              hb_we,
  input  logic [AW-1:0]     hb_addr,
  input  logic [7:0]        hb_wdata,
  input  logic [AW-1:0]     hb_raddr,
  output logic [7:0]        hb_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic [7:0]        cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic [7:0]        rsp_data
);
  import tws_xfer_pkg::*;

  cmd_t          cmd_q;
  err_e          err_q;
  logic          seq_we, gap_load, gap_running;
  logic [AW-1:0] seq_waddr, seq_raddr;
  logic [7:0]    seq_wdata, seq_rdata;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;

  // the sequencer owns the write port during a transfer
  assign mem_we    = seq_we || (hb_we && !busy);
  assign mem_waddr = seq_we ? seq_waddr : hb_addr;
  assign mem_wdata = seq_we ? seq_wdata : hb_wdata;

  tws_xfer_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .ra_addr (hb_raddr),
    .ra_data (hb_rdata),
    .rb_addr (seq_raddr),
    .rb_data (seq_rdata)
  );

  tws_gap_timer #(.CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (gap_load),
    .running (gap_running)
  );

  tws_xfer_seq #(.DEPTH(BUF_DEPTH), .CHUNK(CHUNK), .POLL_W(POLL_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_legacy  (req_legacy),
    .req_dev     (req_dev),
    .req_offset  (req_offset),
    .req_len     (req_len),
    .poll_limit  (poll_limit),
    .busy        (busy),
    .done        (done),
    .err_code    (err_q),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_q       (cmd_q),
    .rsp_valid   (rsp_valid),
    .rsp_ack     (rsp_ack),
    .rsp_data    (rsp_data),
    .buf_we      (seq_we),
    .buf_waddr   (seq_waddr),
    .buf_wdata   (seq_wdata),
    .buf_raddr   (seq_raddr),
    .buf_rdata   (seq_rdata),
    .gap_load    (gap_load),
    .gap_running (gap_running)
  );

  assign err_code  = err_q;
  assign cmd_op    = cmd_q.op;
  assign cmd_start = cmd_q.start;
  assign cmd_stop  = cmd_q.stop;
  assign cmd_data  = cmd_q.data;

endmodule

// File: tb/tws_xfer_ctrl_tb.sv
module tws_xfer_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CHUNK = 4;
  localparam int GAP   = 8;
  localparam int PW    = 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_legacy = 0;
  logic [6:0] req_dev = 0;
  logic [7:0] req_offset = 0;
  logic [LW-1:0] req_len = 0;
  logic [PW-1:0] poll_limit = 0;
  logic busy, done;
  logic [1:0] err_code;
  logic hb_we = 0;
  logic [AW-1:0] hb_addr = 0, hb_raddr = 0;
  logic [7:0] hb_wdata = 0, hb_rdata;
  logic cmd_valid, cmd_ready = 0, cmd_start, cmd_stop;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic rsp_valid = 0, rsp_ack = 0;
  logic [7:0] rsp_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tws_xfer_ctrl #(.BUF_DEPTH(DEPTH), .CHUNK(CHUNK), .GAP_CYCLES(GAP), .POLL_W(PW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_legacy(req_legacy), .req_dev(req_dev), .req_offset(req_offset),
    .req_len(req_len), .poll_limit(poll_limit), .busy(busy), .done(done),
    .err_code(err_code), .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
    .hb_raddr(hb_raddr), .hb_rdata(hb_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data));

  typedef struct {
    logic [11:0] cmd;
    logic        ack;
    logic [7:0]  rd;
    bit          gap;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int cyc = 0, last_rsp_cyc = 0, rsp_cnt = 0;
  logic pend_ack = 0;
  logic [7:0] pend_rd = 0;
  bit   held = 0;
  logic [11:0] held_cmd = 0;

  task automatic check(bit ok, string r, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", r, what, act, expv);
    end
  endtask

  task automatic push(logic [1:0] op, logic st, logic sp, logic [7:0] d,
                      logic ack, logic [7:0] rd, bit gap, string tag);
    exp_t e;
    e.cmd = {op, st, sp, d}; e.ack = ack; e.rd = rd; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  // engine model and scoreboard monitor, all on the falling edge
  always @(negedge clk) begin
    bit rdy;
    exp_t e;
    cyc++;
    rsp_valid = 0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        rsp_valid = 1; rsp_ack = pend_ack; rsp_data = pend_rd; last_rsp_cyc = cyc;
      end
    end
    if (held)
      check(cmd_valid && {cmd_op, cmd_start, cmd_stop, cmd_data} == held_cmd,
            "R11", "held command changed", {cmd_op, cmd_start, cmd_stop, cmd_data}, held_cmd);
    rdy = (cyc % 3) != 1;
    cmd_ready = rdy;
    held = cmd_valid && !rdy;
    held_cmd = {cmd_op, cmd_start, cmd_stop, cmd_data};
    if (cmd_valid && rdy && !rst) begin
      if (q.size() == 0) begin
        check(0, "R13", "unexpected command", {cmd_op, cmd_start, cmd_stop, cmd_data}, 0);
      end else begin
        e = q.pop_front();
        check({cmd_op, cmd_start, cmd_stop, cmd_data} == e.cmd, e.tag, "command",
              {cmd_op, cmd_start, cmd_stop, cmd_data}, e.cmd);
        if (e.gap) check(cyc - last_rsp_cyc >= GAP, "R2", "read address gap",
                         cyc - last_rsp_cyc, GAP);
        pend_ack = e.ack; pend_rd = e.rd; rsp_cnt = 2;
      end
    end
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic request(bit wr, bit leg, logic [6:0] dev, logic [7:0] off,
                         int len, int plim);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_legacy = leg; req_dev = dev;
    req_offset = off; req_len = LW'(len); poll_limit = PW'(plim);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(int exp_err, string r);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check(done, r, "done seen", done, 1);
    check(err_code == 2'(exp_err), r, "err_code", err_code, exp_err);
    check(q.size() == 0, r, "commands left", q.size(), 0);
    q.delete();
    @(negedge clk);
  endtask

  task automatic load_buf(int len, logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      hb_we = 1; hb_addr = AW'(i); hb_wdata = base + 8'(i);
    end
    @(negedge clk);
    hb_we = 0;
  endtask

  task automatic check_buf(int len, logic [7:0] base, string r);
    for (int i = 0; i < len; i++) begin
      hb_raddr = AW'(i);
      @(negedge clk);
      check(hb_rdata == base + 8'(i), r, "buffer byte", hb_rdata, base + 8'(i));
    end
  endtask

  task automatic exp_read(bit leg, logic [6:0] dev, logic [7:0] off, int len,
                          logic [7:0] base, string r);
    if (leg) begin
      push(0, 1, 0, {off[6:0], 1'b1}, 1, 0, 0, "R3");
    end else begin
      push(0, 1, 0, {dev, 1'b0}, 1, 0, 0, "R1");
      push(0, 0, 0, off, 1, 0, 0, "R1");
      push(0, 1, 0, {dev, 1'b1}, 1, 0, 1, "R1");
    end
    for (int i = 0; i < len; i++)
      push((i == len-1) ? 2'd2 : 2'd1, 0, i == len-1, 0, 1, base + 8'(i), 0, r);
  endtask

  task automatic exp_write(bit leg, logic [6:0] dev, logic [7:0] off, int len,
                           int nacks, logic [7:0] base);
    int rem = len, idx = 0;
    logic [7:0] o = off;
    while (rem > 0) begin
      int n = (rem > CHUNK) ? CHUNK : rem;
      if (leg) push(0, 1, 0, {o[6:0], 1'b0}, 1, 0, 0, "R3");
      else begin
        push(0, 1, 0, {dev, 1'b0}, 1, 0, 0, "R5");
        push(0, 0, 0, o, 1, 0, 0, "R5");
      end
      for (int j = 0; j < n; j++) begin
        push(0, 0, j == n-1, base + 8'(idx), 1, 0, 0, "R5");
        idx++;
      end
      for (int k = 0; k < nacks; k++) push(0, 1, 0, {dev, 1'b1}, 0, 0, 0, "R6");
      push(0, 1, 0, {dev, 1'b1}, 1, 0, 0, "R6");
      push(2, 0, 1, 0, 1, 8'h5A, 0, "R6");
      rem -= n;
      o += 8'(CHUNK);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!busy && !done && !cmd_valid, "R12", "reset outputs",
          {busy, done, cmd_valid}, 0);
    rst = 0;
    @(negedge clk);

    // register-addressed write, two chunks, two refused polls each
    load_buf(6, 8'hA0);
    exp_write(0, 7'h50, 8'h10, 6, 2, 8'hA0);
    request(1, 0, 7'h50, 8'h10, 6, 5);
    wait_done(0, "R5");

    // register-addressed read, with an ignored request while busy
    exp_read(0, 7'h50, 8'h10, 5, 8'h30, "R4");
    request(0, 0, 7'h50, 8'h10, 5, 5);
    repeat (4) @(negedge clk);
    check(busy, "R13", "busy during transfer", busy, 1);
    req_valid = 1; req_write = 1; req_legacy = 1; req_offset = 8'h77; req_len = LW'(3);
    @(negedge clk);
    req_valid = 0;
    wait_done(0, "R13");
    check_buf(5, 8'h30, "R4");

    // single-byte read: only a NACK read
    exp_read(0, 7'h21, 8'hFE, 1, 8'hC4, "R4");
    request(0, 0, 7'h21, 8'hFE, 1, 5);
    wait_done(0, "R4");
    check_buf(1, 8'hC4, "R4");

    // legacy read
    exp_read(1, 7'h50, 8'h23, 3, 8'h61, "R3");
    request(0, 1, 7'h50, 8'h23, 3, 5);
    wait_done(0, "R3");
    check_buf(3, 8'h61, "R3");

    // legacy write, offsets 0x05 then 0x09
    load_buf(5, 8'h10);
    exp_write(1, 7'h51, 8'h05, 5, 1, 8'h10);
    request(1, 1, 7'h51, 8'h05, 5, 5);
    wait_done(0, "R3");

    // device byte refused on a write
    push(0, 1, 0, {7'h50, 1'b0}, 0, 0, 0, "R7");
    push(3, 0, 1, 0, 1, 0, 0, "R7");
    request(1, 0, 7'h50, 8'h00, 2, 5);
    wait_done(1, "R7");

    // offset byte refused on a read
    push(0, 1, 0, {7'h50, 1'b0}, 1, 0, 0, "R7");
    push(0, 0, 0, 8'h40, 0, 0, 0, "R7");
    push(3, 0, 1, 0, 1, 0, 0, "R7");
    request(0, 0, 7'h50, 8'h40, 2, 5);
    wait_done(1, "R7");

    // poll timeout after three refusals
    load_buf(2, 8'hE0);
    push(0, 1, 0, {7'h52, 1'b0}, 1, 0, 0, "R8");
    push(0, 0, 0, 8'h08, 1, 0, 0, "R8");
    push(0, 0, 0, 8'hE0, 1, 0, 0, "R8");
    push(0, 0, 1, 8'hE1, 1, 0, 0, "R8");
    for (int k = 0; k < 3; k++) push(0, 1, 0, {7'h52, 1'b1}, 0, 0, 0, "R8");
    push(3, 0, 1, 0, 1, 0, 0, "R8");
    request(1, 0, 7'h52, 8'h08, 2, 3);
    wait_done(3, "R8");

    // data byte refused
    load_buf(3, 8'h70);
    push(0, 1, 0, {7'h50, 1'b0}, 1, 0, 0, "R9");
    push(0, 0, 0, 8'h20, 1, 0, 0, "R9");
    push(0, 0, 0, 8'h70, 1, 0, 0, "R9");
    push(0, 0, 0, 8'h71, 0, 0, 0, "R9");
    push(3, 0, 1, 0, 1, 0, 0, "R9");
    request(1, 0, 7'h50, 8'h20, 3, 5);
    wait_done(2, "R9");

    // zero length: no command at all
    request(1, 0, 7'h50, 8'h00, 0, 5);
    wait_done(0, "R10");
    repeat (20) @(negedge clk);
    check(!busy && !cmd_valid, "R10", "still idle", {busy, cmd_valid}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule